// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block sits on the device side of a register-mapped secure-module interface. Up to `NUM_LOC` software localities share one interface, and at most one of them may own it at a time. Each locality has its own access register. The registers are spaced `2**LOC_SHIFT` bytes apart, which is 4 KiB by default. Locality `n` is reached at byte address `n << LOC_SHIFT`, and the low `LOC_SHIFT` address bits must be zero.

Software asks for ownership by writing the request-use command to its own register. It gives ownership up by writing the release command to that same register. Reading a register shows four things: whether the interface has finished initialising, whether this locality is the owner, whether its own request is still waiting, and whether any other locality is waiting. Software treats a locality as the owner only when the valid bit and the active bit both read 1.

The block also drives three plain status outputs: the current owner, an owner-present flag, and a one-cycle change pulse that a neighbouring interrupt block can use as a locality-change cause. The interface has no data stream, so there is no valid/ready handshake. Writes take effect at the clock edge on which they are presented. Reads are combinational from the current state. When several localities are waiting, the highest-numbered one is granted first.

Top module: `locality_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, no owner is reported (`owner_valid`=0, `owner_id`=0, `owner_chg`=0), and every access register reads 0x00.
- R2: Bit 7 (0x80) of every access register reads 1 from the cycle after `init_done` is first sampled high at a clock edge. It stays 1 even if `init_done` later falls.
- R3: Any write presented while bit 7 still reads 0 is ignored. This includes a write on the same edge at which `init_done` is first sampled high.
- R4: When nobody owns the interface, a request (write data exactly 0x02) to locality L makes L the owner from the next cycle. Bit 5 (0x20) of L's register then reads 1, and bit 5 of every other register reads 0.
- R5: A request from a locality that is not the owner, made while another locality owns the interface, leaves it waiting. Bit 1 (0x02) of its own register reads 1, and bit 2 (0x04) reads 1 in the register of every other locality. A locality does not see its own request in bit 2.
- R6: A release by the owner (write data exactly 0x20 to the owner's register) passes ownership, on that same edge, to the highest-numbered waiting locality. That locality's waiting bit clears. If nobody is waiting, no owner remains.
- R7: A release written to a register that is not the owner's has no effect. A request written by the current owner has no effect.
- R8: Write data other than exactly 0x02 or 0x20 is ignored. Writes whose low `LOC_SHIFT` address bits are non-zero are ignored, and so are writes whose locality field is `NUM_LOC` or more. Reads at such addresses return 0x00.
- R9: `owner_chg` is 1 for exactly the cycles in which `owner_valid`/`owner_id` differ from their values in the previous cycle. This covers gaining an owner, a direct handover and losing the owner.
- R10: `owner_valid`/`owner_id` always agree with the access registers. Bit 5 reads 1 only in register `owner_id`, and `owner_id` reads 0 whenever there is no owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Initialisation finished; sets the sticky valid bit |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational; 0 when no mapped read is in progress |
| owner_valid | output | 1 | A locality owns the interface |
| owner_id | output | LOC_W | Number of the owning locality |
| owner_chg | output | 1 | One-cycle pulse on any change of owner |

## Verification
A release by the owner and the grant to the next waiting locality happen on the same edge. Releasing the owner while two other localities are waiting therefore provokes a handover in a single cycle. The bench judges this by requiring the new owner, the cleared waiting bit and a single `owner_chg` pulse, with no idle cycle in between. The first `init_done` sample can also coincide with a request write. The bench presents both together and expects the write to be dropped while the valid bit appears on the next cycle.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // access register bit positions (software decodes these)
  localparam int BIT_VALID  = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_OTHERS = 2;
  localparam int BIT_OWNREQ = 1;

  // command codes written to an access register
  localparam logic [7:0] CMD_REQUEST = 8'h02;
  localparam logic [7:0] CMD_RELEASE = 8'h20;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_REQUEST = 2'd1,
    OP_RELEASE = 2'd2
  } loc_op_e;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LOC_SHIFT = 12,
  parameter int LOC_W     = 3
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              accept,
  output loc_op_e           op,
  output logic [LOC_W-1:0]  op_loc,
  output logic              rd_hit,
  output logic [LOC_W-1:0]  rd_loc
);
  localparam int FIELD_W = ADDR_W - LOC_SHIFT;

  logic [FIELD_W-1:0] field;
  logic               mapped;

  assign field  = bus_addr[ADDR_W-1:LOC_SHIFT];
  assign mapped = (bus_addr[LOC_SHIFT-1:0] == '0) && (int'(field) < NUM_LOC);

  assign op_loc = LOC_W'(field);
  assign rd_loc = LOC_W'(field);
  assign rd_hit = bus_en && !bus_we && mapped;

  always_comb begin
    op = OP_NONE;
    if (bus_en && bus_we && mapped && accept) begin
      if (bus_wdata == DATA_W'(CMD_REQUEST))      op = OP_REQUEST;
      else if (bus_wdata == DATA_W'(CMD_RELEASE)) op = OP_RELEASE;
    end
  end
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] cand,
  output logic               any,
  output logic [LOC_W-1:0]   idx
);
  // highest-numbered candidate wins
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (cand[i]) idx = LOC_W'(i);
    end
  end
  assign any = |cand;
endmodule

// File: rtl/loc_arb_core.sv
module loc_arb_core
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_done,
  input  loc_op_e            op,
  input  logic [LOC_W-1:0]   op_loc,
  output logic               valid_o,
  output logic               owner_v_o,
  output logic [LOC_W-1:0]   owner_id_o,
  output logic [NUM_LOC-1:0] pend_o,
  output logic               chg_o
);
  logic               valid_q, owner_v_q, chg_q;
  logic [LOC_W-1:0]   owner_q;
  logic [NUM_LOC-1:0] pend_q;

  logic               is_owner, rel_ok, req_ok, held_v;
  logic [NUM_LOC-1:0] loc_bit, pend_add;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;
  logic               v_nxt;
  logic [LOC_W-1:0]   id_nxt;
  logic [NUM_LOC-1:0] pend_nxt;

  assign is_owner = owner_v_q && (owner_q == op_loc);
  assign rel_ok   = (op == OP_RELEASE) && is_owner;
  assign req_ok   = (op == OP_REQUEST) && !is_owner;
  assign loc_bit  = NUM_LOC'(1) << op_loc;
  assign pend_add = pend_q | (req_ok ? loc_bit : '0);
  assign held_v   = owner_v_q && !rel_ok;

  loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) pick_i (
    .cand (pend_add),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  always_comb begin
    v_nxt    = held_v;
    id_nxt   = held_v ? owner_q : '0;
    pend_nxt = pend_add;
    if (!held_v && pick_any) begin
      v_nxt    = 1'b1;
      id_nxt   = pick_idx;
      pend_nxt = pend_add & ~(NUM_LOC'(1) << pick_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      owner_v_q <= 1'b0;
      owner_q   <= '0;
      pend_q    <= '0;
      chg_q     <= 1'b0;
    end else begin
      valid_q   <= valid_q | init_done;
      owner_v_q <= v_nxt;
      owner_q   <= id_nxt;
      pend_q    <= pend_nxt;
      chg_q     <= (v_nxt != owner_v_q) || (id_nxt != owner_q);
    end
  end

  assign valid_o    = valid_q;
  assign owner_v_o  = owner_v_q;
  assign owner_id_o = owner_q;
  assign pend_o     = pend_q;
  assign chg_o      = chg_q;
endmodule

// File: rtl/loc_arb_rdmux.sv
module loc_arb_rdmux #(
  parameter int NUM_LOC = 5,
  parameter int DATA_W  = 8,
  parameter int LOC_W   = 3
) (
  input  logic               valid,
  input  logic               owner_v,
  input  logic [LOC_W-1:0]   owner_id,
  input  logic [NUM_LOC-1:0] pend,
  input  logic               rd_hit,
  input  logic [LOC_W-1:0]   rd_loc,
  output logic [DATA_W-1:0]  rdata
);
  logic [NUM_LOC-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_reg
    logic act, others;
    assign act    = owner_v && (owner_id == LOC_W'(g));
    assign others = |(pend & ~(NUM_LOC'(1) << g));
    // layout: valid(7) active(5) others-waiting(2) own-request(1)
    assign regs[g] = DATA_W'({valid, 1'b0, act, 2'b00, others, pend[g], 1'b0});
  end

  assign rdata = rd_hit ? regs[rd_loc] : '0;
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC   = 5,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LOC_SHIFT = 12,
  localparam int LOC_W    = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              owner_valid,
  output logic [LOC_W-1:0]  owner_id,
  output logic              owner_chg
);
  loc_op_e            op;
  logic [LOC_W-1:0]   op_loc, rd_loc;
  logic               rd_hit, valid_q;
  logic [NUM_LOC-1:0] pend;

  loc_arb_decode #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOC_SHIFT(LOC_SHIFT), .LOC_W(LOC_W)
  ) dec_i (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .accept    (valid_q),
    .op        (op),
    .op_loc    (op_loc),
    .rd_hit    (rd_hit),
    .rd_loc    (rd_loc)
  );

  loc_arb_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_done  (init_done),
    .op         (op),
    .op_loc     (op_loc),
    .valid_o    (valid_q),
    .owner_v_o  (owner_valid),
    .owner_id_o (owner_id),
    .pend_o     (pend),
    .chg_o      (owner_chg)
  );

  loc_arb_rdmux #(.NUM_LOC(NUM_LOC), .DATA_W(DATA_W), .LOC_W(LOC_W)) rd_i (
    .valid    (valid_q),
    .owner_v  (owner_valid),
    .owner_id (owner_id),
    .pend     (pend),
    .rd_hit   (rd_hit),
    .rd_loc   (rd_loc),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/loc_arb_chk.sv
module loc_arb_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               valid_q,
  input logic               owner_valid,
  input logic [LOC_W-1:0]   owner_id,
  input logic               owner_chg,
  input logic [NUM_LOC-1:0] pend
);
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_q) |-> valid_q); // R2

  AST_NO_OWNER_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (!owner_valid && pend == '0)); // R3

  AST_NO_IDLE_WITH_WAITERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> owner_valid); // R6

  AST_OWNER_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid |-> !pend[owner_id]); // R5

  AST_CHG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    owner_chg == ((owner_valid != $past(owner_valid)) || (owner_id != $past(owner_id)))); // R9

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid |-> (int'(owner_id) < NUM_LOC)); // R10

  AST_ID_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !owner_valid |-> (owner_id == '0)); // R10
endmodule

bind locality_arbiter loc_arb_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_q     (valid_q),
  .owner_valid (owner_valid),
  .owner_id    (owner_id),
  .owner_chg   (owner_chg),
  .pend        (pend)
);

// File: tb/locality_arbiter_tb_top.sv
`timescale 1ns/1ps
module locality_arbiter_tb_top;
  localparam int NL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        owner_valid, owner_chg;
  logic [2:0]  owner_id;

  int n_chk = 0, n_bad = 0;

  // bench-side model state
  bit       m_valid, m_ov, m_chg;
  int       m_oid;
  bit [4:0] m_pend;

  always #5 clk = ~clk;

  locality_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .owner_valid(owner_valid), .owner_id(owner_id), .owner_chg(owner_chg)
  );

  task automatic cmp(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int exp_reg(input int l);
    int v = 0;
    if (m_valid) v |= 8'h80;
    if (m_ov && m_oid == l) v |= 8'h20;
    if ((m_pend & ~(5'b1 << l)) != 0) v |= 8'h04;
    if (m_pend[l]) v |= 8'h02;
    return v;
  endfunction

  task automatic check_all(input string rq);
    cmp(rq, "owner_valid", int'(owner_valid), int'(m_ov));
    cmp(rq, "owner_id", int'(owner_id), m_ov ? m_oid : 0);
    cmp("R9", "owner_chg", int'(owner_chg), int'(m_chg));
    for (int l = 0; l < NL; l++) begin
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 16'(l << 12);
      #0.4;
      cmp(rq, $sformatf("reg%0d", l), int'(bus_rdata), exp_reg(l));
    end
    bus_en = 1'b0;
  endtask

  task automatic model(input bit en, input bit we, input bit [15:0] a,
                       input bit [7:0] d, input bit idn);
    bit pov = m_ov; int pid = m_oid; int l = int'(a[15:12]);
    if (en && we && m_valid && a[11:0] == 0 && l < NL) begin
      if (d == 8'h02 && !(m_ov && m_oid == l)) m_pend[l] = 1'b1;
      else if (d == 8'h20 && m_ov && m_oid == l) begin m_ov = 0; m_oid = 0; end
    end
    if (!m_ov && m_pend != 0) begin
      for (int i = 0; i < NL; i++) if (m_pend[i]) m_oid = i;
      m_ov = 1; m_pend[m_oid] = 1'b0;
    end
    m_chg = (pov != m_ov) || (pid != m_oid);
    m_valid = m_valid | idn;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input bit we, input bit [15:0] a, input bit [7:0] d,
                      input bit idn, input string rq);
    bus_en = we; bus_we = we; bus_addr = a; bus_wdata = d; init_done = idn;
    @(posedge clk);
    model(we, we, a, d, idn);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    check_all(rq);
  endtask

  function automatic bit [15:0] la(input int l);
    return 16'(l << 12);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "owner_chg in reset", int'(owner_chg), 0);
    cmp("R1", "owner_valid in reset", int'(owner_valid), 0);
    rst_n = 1'b1;
    m_chg = 0;
    check_all("R1");

    // writes before init finishes are dropped
    step(1, la(2), 8'h02, 0, "R3");
    step(1, la(0), 8'h02, 0, "R3");
    // init_done seen on the same edge as a request: request dropped, valid next
    step(1, la(3), 8'h02, 1, "R3");
    step(0, la(0), 8'h00, 1, "R2");
    // idle grant
    step(1, la(2), 8'h02, 1, "R4");
    // waiters
    step(1, la(1), 8'h02, 1, "R5");
    step(1, la(4), 8'h02, 1, "R5");
    // owner request and foreign release ignored
    step(1, la(2), 8'h02, 1, "R7");
    step(1, la(1), 8'h20, 1, "R7");
    // bad data, bad offset, unmapped locality
    step(1, la(2), 8'h22, 1, "R8");
    step(1, la(2) | 16'h0004, 8'h20, 1, "R8");
    step(1, la(5), 8'h02, 1, "R8");
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = la(2) | 16'h0010; #0.4;
    cmp("R8", "unmapped offset read", int'(bus_rdata), 0);
    bus_addr = la(6); #0.4;
    cmp("R8", "unmapped locality read", int'(bus_rdata), 0);
    bus_en = 1'b0;
    // handover to highest waiter, then next, then idle
    step(1, la(2), 8'h20, 1, "R6");
    step(1, la(4), 8'h20, 1, "R6");
    step(1, la(1), 8'h20, 1, "R6");
    // valid bit stays when init_done falls
    step(0, la(0), 8'h00, 0, "R2");
    step(1, la(0), 8'h02, 0, "R4");

    for (int k = 0; k < 400; k++) begin
      int loc = int'($urandom % 6);
      int kind = int'($urandom % 8);
      bit [11:0] off = ($urandom % 8 == 0) ? 12'(($urandom % 4095) + 1) : 12'h000;
      bit [7:0] d = (kind < 3) ? 8'h02 : (kind < 6) ? 8'h20 : 8'($urandom);
      step(kind != 7, {4'(loc), off}, d, 1'($urandom % 2), "R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule